// File: doc/BRIEF.md
# I2C SCL timing generator

This block derives the serial clock waveform of an I2C master from the system clock. A programmable base count sets the length of one time unit. Standard timing spends one unit low and one unit high per bit, giving a period of twice the count. Fast and fast-plus timing spend two units low and one unit high, giving a period of three times the count. The block drives the clock line low or releases it. It also issues a one-cycle strobe when data may change and a one-cycle strobe when data should be sampled.

While the line is released, the block watches the sampled clock line. If a target holds the line low to stretch the clock, the high-phase count stops and waits. Each low phase that follows a high phase places the data-change strobe a programmable number of cycles into that low phase. This gives the data line its setup time once the stretch has ended. The low phase grows when needed so that this strobe always comes before the line is released. A transaction engine above the block uses the two strobes to shift bits out and in.

Top module: `i2cbr_gen`

## Requirements
- R1: After reset the clock line is released (`scl_pull_low` = 0) and neither strobe is asserted.
- R2: While `en` is 0 the block stays idle, with the line released and no strobes, from the cycle after `en` is seen low. In the cycle after `en` is first seen high in idle, a low phase starts.
- R3: With `speed_mode` = 0 (standard), each low phase lasts U cycles and each unstretched high phase lasts U cycles, where U is `baud_count` (when the setup rule R8 does not extend the low phase).
- R4: With `speed_mode` = 1 (fast) or 3 (fast plus), each low phase lasts 2·U cycles and each unstretched high phase lasts U cycles.
- R5: `speed_mode` = 2 (high speed, not supported here) uses the standard timing of R3.
- R6: A `baud_count` of 0 gives the same timing as a `baud_count` of 1.
- R7: `data_change` pulses for exactly one cycle in each low phase. It pulses in cycle `setup_count`+1 of that phase, so a setup count of 0 means the first low cycle.
- R8: When `setup_count`+2 is greater than the low length from R3 to R5, the low phase lasts `setup_count`+2 cycles instead.
- R9: `data_sample` pulses for one cycle in each high phase. It pulses in the first released cycle where `scl_in` reads 1, and only while the line is released.
- R10: During a high phase, any cycle with `scl_in` = 0 is not counted. The high phase ends after U cycles with `scl_in` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run the clock generator |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 high speed (standard timing), 3 fast plus |
| baud_count | input | 16 | Cycles per time unit (0 treated as 1) |
| setup_count | input | 16 | Data-change delay into the low phase, in cycles minus one |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_pull_low | output | 1 | 1 drives the clock line low, 0 releases it |
| data_change | output | 1 | One-cycle strobe: data may be changed now |
| data_sample | output | 1 | One-cycle strobe: data should be sampled now |

## Verification
The bench loops the released clock line back through a one-cycle delay, so every rising edge looks like a one-cycle stretch. It also adds long stretch windows that hold the line low across several high cycles. A design that kept counting while stretched would release the low phase early and shorten the period. The bench covers a zero baud count, which would stall a counter that compares against count minus one. It uses a setup count longer than the low time, which without the extension would drop the data-change strobe or place it in the high phase. It also sets the high-speed mode code, which a wrong decode would run at fast timing. Dropping the enable in the middle of a bit checks that the line is released at once and that the next enable starts again with a full low phase.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

  // Speed mode codes as presented on speed_mode
  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_HS    = 2'd2,
    SPD_FPLUS = 2'd3
  } spd_e;

  // Clock generator phase
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } ph_e;

endpackage

// File: rtl/i2cbr_limits.sv
module i2cbr_limits
  import i2cbr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic [1:0]       speed_mode,
  input  logic [CNT_W-1:0] baud_count,
  input  logic [CNT_W-1:0] setup_count,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len
);

  logic [CNT_W-1:0] unit_w;
  logic             wide_low;
  logic [LEN_W-1:0] base_low;
  logic [LEN_W-1:0] setup_low;

  // zero base count would never reach its end value
  always_comb begin
    if (baud_count == '0) unit_w = CNT_W'(1);
    else                  unit_w = baud_count;
  end

  always_comb begin
    unique case (spd_e'(speed_mode))
      SPD_FAST, SPD_FPLUS: wide_low = 1'b1;
      SPD_STD, SPD_HS:     wide_low = 1'b0;
      default:             wide_low = 1'b0;
    endcase
  end

  always_comb begin
    if (wide_low) base_low = {1'b0, unit_w, 1'b0};
    else          base_low = {2'b00, unit_w};
    setup_low = {2'b00, setup_count} + LEN_W'(2);
    low_len   = (setup_low > base_low) ? setup_low : base_low;
    high_len  = {2'b00, unit_w};
  end

endmodule

// File: rtl/i2cbr_seq.sv
module i2cbr_seq
  import i2cbr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             scl_in,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  input  logic [CNT_W-1:0] setup_count,
  output logic             pull_low,
  output logic             change_stb,
  output logic             sample_stb,
  output ph_e              phase
);

  ph_e              ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             upd;
  logic             low_end;
  logic             high_end;

  assign low_end  = (cnt_q == (low_len - LEN_W'(1)));
  assign high_end = (cnt_q == (high_len - LEN_W'(1)));

  // next state
  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d  = PH_LOW;
          cnt_d = '0;
        end
        PH_LOW: begin
          if (low_end) begin
            ph_d  = PH_HIGH;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (scl_in) begin
            if (high_end) begin
              ph_d  = PH_LOW;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign upd = en || (ph_q != PH_IDLE);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (upd) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign pull_low   = (ph_q == PH_LOW);
  assign change_stb = (ph_q == PH_LOW) && (cnt_q == {2'b00, setup_count});
  assign sample_stb = (ph_q == PH_HIGH) && (cnt_q == '0) && scl_in;
  assign phase      = ph_q;

endmodule

// File: rtl/i2cbr_gen.sv
module i2cbr_gen
  import i2cbr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       speed_mode,
  input  logic [CNT_W-1:0] baud_count,
  input  logic [CNT_W-1:0] setup_count,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             data_change,
  output logic             data_sample
);

  localparam int LEN_W = CNT_W + 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  logic [LEN_W-1:0]       low_len;
  logic [LEN_W-1:0]       high_len;
  ph_e                    cur_phase;

  // reset release synchronizer
  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end
  endgenerate

  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  i2cbr_limits #(
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
  ) u_limits (
    .speed_mode  (speed_mode),
    .baud_count  (baud_count),
    .setup_count (setup_count),
    .low_len     (low_len),
    .high_len    (high_len)
  );

  i2cbr_seq #(
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .en          (en),
    .scl_in      (scl_in),
    .low_len     (low_len),
    .high_len    (high_len),
    .setup_count (setup_count),
    .pull_low    (scl_pull_low),
    .change_stb  (data_change),
    .sample_stb  (data_sample),
    .phase       (cur_phase)
  );

endmodule

// File: rtl/i2cbr_chk.sv
module i2cbr_chk
  import i2cbr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             scl_in,
  input logic [CNT_W-1:0] baud_count,
  input logic             scl_pull_low,
  input logic             data_change,
  input logic             data_sample,
  input ph_e              phase
);

  localparam int RUN_W = CNT_W + 3;

  logic [RUN_W-1:0] low_run;
  logic [RUN_W-1:0] unit_chk;

  assign unit_chk = (baud_count == '0) ? RUN_W'(1) : RUN_W'(baud_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_run <= '0;
    else if (!scl_pull_low)         low_run <= '0;
    else if (low_run != '1)         low_run <= low_run + RUN_W'(1);
  end

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    data_sample |-> (!scl_pull_low && scl_in)); // R9

  AST_CHANGE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    data_change |-> scl_pull_low); // R7

  AST_CHANGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_change |=> !data_change); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull_low && !data_change && !data_sample)); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == PH_IDLE) |=> scl_pull_low); // R2

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == PH_HIGH && !scl_in) |=> (phase == PH_HIGH)); // R10

  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_low) && $past(en)) |-> (low_run >= unit_chk)); // R3

endmodule

bind i2cbr_gen i2cbr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_s_n),
  .en           (en),
  .scl_in       (scl_in),
  .baud_count   (baud_count),
  .scl_pull_low (scl_pull_low),
  .data_change  (data_change),
  .data_sample  (data_sample),
  .phase        (cur_phase)
);

// File: tb/sim_i2cbr_gen.sv
module sim_i2cbr_gen;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [1:0]  speed_mode;
  logic [15:0] baud_count;
  logic [15:0] setup_count;
  logic        scl_in;
  logic        scl_pull_low;
  logic        data_change;
  logic        data_sample;

  int n_cmp;
  int n_bad;
  int cyc;
  int stretch_on;
  bit done;

  // behavioural reference: 0 idle, 1 low, 2 high
  int m_ph;
  int m_cnt;

  i2cbr_gen u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .speed_mode   (speed_mode),
    .baud_count   (baud_count),
    .setup_count  (setup_count),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .data_change  (data_change),
    .data_sample  (data_sample)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int unit_len();
    return (baud_count == 0) ? 1 : int'(baud_count);
  endfunction

  function automatic int low_total();
    int l;
    l = (speed_mode == 2'd1 || speed_mode == 2'd3) ? 2 * unit_len() : unit_len();
    if (int'(setup_count) + 2 > l) l = int'(setup_count) + 2;
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_ph  = 0;
      m_cnt = 0;
    end else if (m_ph == 0) begin
      m_ph  = 1;
      m_cnt = 0;
    end else if (m_ph == 1) begin
      m_cnt = m_cnt + 1;
      if (m_cnt >= low_total()) begin
        m_ph  = 2;
        m_cnt = 0;
      end
    end else if (scl_in) begin
      m_cnt = m_cnt + 1;
      if (m_cnt >= unit_len()) begin
        m_ph  = 1;
        m_cnt = 0;
      end
    end
  end

  task automatic tick(input string tag);
    bit e_low, e_chg, e_smp;
    @(negedge clk);
    e_low = (m_ph == 1);
    e_chg = (m_ph == 1) && (m_cnt == int'(setup_count));
    e_smp = (m_ph == 2) && (m_cnt == 0) && scl_in;
    n_cmp++;
    if ({scl_pull_low, data_change, data_sample} !== {e_low, e_chg, e_smp}) begin
      n_bad++;
      $display("FAIL %s cycle %0d: low/change/sample got %b%b%b expected %b%b%b",
               tag, cyc, scl_pull_low, data_change, data_sample, e_low, e_chg, e_smp);
    end
    cyc++;
    // open-drain loopback with one cycle of rise delay, plus optional target hold
    scl_in = !scl_pull_low && !(stretch_on != 0 && (cyc % 13) < 5);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic setup_cfg(input logic [1:0] m, input int b, input int s, input string tag);
    en = 1'b0;
    run(3, tag);
    speed_mode  = m;
    baud_count  = 16'(b);
    setup_count = 16'(s);
    en = 1'b1;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; stretch_on = 0; done = 1'b0;
    m_ph = 0; m_cnt = 0;
    rst_n = 1'b1; en = 1'b0; speed_mode = 2'd0;
    baud_count = 16'd4; setup_count = 16'd1; scl_in = 1'b1;
    #1 rst_n = 1'b0;
    run(4, "R1");
    rst_n = 1'b1;
    run(6, "R1");

    setup_cfg(2'd0, 4, 1, "R2");
    run(60, "R3/R7/R9");
    setup_cfg(2'd1, 3, 0, "R2");
    run(60, "R4/R7");
    setup_cfg(2'd3, 5, 2, "R2");
    run(70, "R4/R9");
    setup_cfg(2'd2, 3, 0, "R2");
    run(50, "R5");
    setup_cfg(2'd0, 0, 0, "R2");
    run(30, "R6");
    setup_cfg(2'd1, 0, 0, "R2");
    run(30, "R6");
    setup_cfg(2'd0, 2, 9, "R2");
    run(60, "R8/R7");
    setup_cfg(2'd1, 2, 6, "R2");
    run(60, "R8");

    stretch_on = 1;
    setup_cfg(2'd0, 3, 1, "R2");
    run(120, "R10/R9");
    setup_cfg(2'd1, 4, 2, "R2");
    run(120, "R10");
    stretch_on = 0;

    // drop the enable part way through a bit, then restart
    setup_cfg(2'd0, 6, 1, "R2");
    run(9, "R3");
    en = 1'b0;
    run(5, "R2");
    en = 1'b1;
    run(40, "R2/R3");
    en = 1'b0;
    run(4, "R2");

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule